// File: doc/BRIEF.md
# Processor Interrupt Entry Controller

This block decides, cycle by cycle, whether a 32-bit soft processor core takes a hardware interrupt. It also applies the control-register side effects of taking one. It holds four control registers:

- a status word, whose bit 0 is the global interrupt enable;
- a saved copy of the status word;
- an interrupt-enable mask;
- a pending-interrupt register.

Software reaches these registers through one write port and a separate clear-by-mask port for the pending bits.

Each cycle the block forms the enabled request set. This is the enable mask ANDed with the raw device request lines. An entry fires when three things hold: the global enable is on, the enabled set is nonzero, and the enabled set differs from the current pending register. A request that is merely held does not fire on every cycle.

On entry the block does the following:

- raises a one-cycle redirect strobe carrying the fixed handler address;
- clears the global enable;
- merges the enabled set into the pending register.

If the exception-handling flag in status was clear, the block also copies the old status into the saved-status register. In that case it also issues a write of the interrupted PC plus 4 to the exception-return general register. If the flag was set, both of these are skipped, which leaves the outer context intact. Every output is registered, so all effects of an entry decided in one cycle appear together after the next clock edge.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset the status register reads 0x00800000. The saved-status, enable and pending registers read zero, and redirect and the return-address write are low.
- R2: No entry occurs while status bit 0 is clear, whatever the requests, enables and pending bits are.
- R3: The enabled request set is the enable register ANDed with the request lines. An entry needs this set to be nonzero, so requests whose enable bit is clear never cause one.
- R4: No entry occurs when the enabled request set equals the current pending register value.
- R5: On entry the enabled request set is ORed into the pending register.
- R6: An entry raises redirect for exactly one cycle with redirect_pc = 0x00000020. It also clears status bit 0 and leaves the other status bits unchanged.
- R7: On an entry with status bit 22 clear, saved-status receives the pre-entry status. In the same cycle ea_wr_en pulses with ea_wr_data equal to the interrupted PC plus 4, modulo 2^32.
- R8: On an entry with status bit 22 set, saved-status is left unchanged and ea_wr_en stays low.
- R9: With sw_clr_en high, every bit set in sw_clr_mask is cleared in the pending register.
- R10: When an entry and a software write target the same register in the same cycle, the entry's update wins. A software write to an untouched register still applies.
- R11: sw_wr_sel selects the written register: 0 status, 1 saved-status, 2 enable, 3 pending. When a pending write and a clear happen together, the write is applied first and the mask then clears bits of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | IRQ_W | Raw device interrupt request lines |
| pc | input | DATA_W | Program counter of the current instruction |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_wr_sel | input | 2 | Register select for the write |
| sw_wr_data | input | DATA_W | Software write data |
| sw_clr_en | input | 1 | Pending clear strobe |
| sw_clr_mask | input | IRQ_W | Bits to clear in pending |
| status_q | output | DATA_W | Status register |
| saved_status_q | output | DATA_W | Saved-status register |
| enable_q | output | IRQ_W | Interrupt enable register |
| pending_q | output | IRQ_W | Pending register |
| redirect | output | 1 | One-cycle entry strobe |
| redirect_pc | output | DATA_W | Handler address during redirect, zero otherwise |
| ea_wr_en | output | 1 | Write strobe for the return-address register |
| ea_wr_data | output | DATA_W | Return address (PC plus 4) |

## Verification
Directed cases cover the following patterns:

- requests with the global enable clear (R2);
- requests masked by a zero enable (R3);
- an enabled set that matches pending exactly (R4), next to a set that is only a subset of pending and still fires;
- entry with the nesting flag clear and with it set (R7 against R8);
- a software status write colliding with an entry (R10);
- a simultaneous pending write and clear (R11).

Random traffic then mixes sparse request vectors, random enable masks, status writes that toggle bit 0 and bit 22, and random clear masks. This separates the entry condition from the register side effects, and each cycle is compared with a reference model kept in the bench.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    CSEL_STATUS  = 2'd0,
    CSEL_SAVED   = 2'd1,
    CSEL_ENABLE  = 2'd2,
    CSEL_PENDING = 2'd3
  } csel_e;
endpackage

// File: rtl/irq_take_decide.sv
module irq_take_decide #(
  parameter int IRQ_W = 32
) (
  input  logic             gie,
  input  logic [IRQ_W-1:0] enable_q,
  input  logic [IRQ_W-1:0] irq_req,
  input  logic [IRQ_W-1:0] pending_q,
  output logic [IRQ_W-1:0] en_set,
  output logic             take
);
  always_comb begin
    en_set = enable_q & irq_req;
    take   = gie && (|en_set) && (en_set != pending_q);
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_entry_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          IRQ_W      = 32,
  parameter int          EH_BIT     = 22,
  parameter logic [31:0] STATUS_RST = 32'h0080_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [IRQ_W-1:0]  en_set,
  input  logic              sw_wr_en,
  input  logic [1:0]        sw_wr_sel,
  input  logic [DATA_W-1:0] sw_wr_data,
  input  logic              sw_clr_en,
  input  logic [IRQ_W-1:0]  sw_clr_mask,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] saved_q,
  output logic [IRQ_W-1:0]  enable_q,
  output logic [IRQ_W-1:0]  pending_q,
  output logic              save_ok
);
  localparam logic [DATA_W-1:0] ST_RST = DATA_W'(STATUS_RST);

  csel_e sel;
  logic  wr_status, wr_saved, wr_enable, wr_pending;
  logic [IRQ_W-1:0] pend_next;

  always_comb begin
    sel        = csel_e'(sw_wr_sel);
    wr_status  = sw_wr_en && (sel == CSEL_STATUS);
    wr_saved   = sw_wr_en && (sel == CSEL_SAVED);
    wr_enable  = sw_wr_en && (sel == CSEL_ENABLE);
    wr_pending = sw_wr_en && (sel == CSEL_PENDING);
    save_ok    = ~status_q[EH_BIT];
  end

  for (genvar i = 0; i < IRQ_W; i++) begin : g_pend
    logic base;
    assign base         = wr_pending ? sw_wr_data[i] : pending_q[i];
    assign pend_next[i] = take ? (pending_q[i] | en_set[i])
                               : (base & ~(sw_clr_en & sw_clr_mask[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= ST_RST;
      saved_q   <= '0;
      enable_q  <= '0;
      pending_q <= '0;
    end else begin
      if (take)           status_q <= {status_q[DATA_W-1:1], 1'b0};
      else if (wr_status) status_q <= sw_wr_data;

      if (take && save_ok) saved_q <= status_q;
      else if (wr_saved)   saved_q <= sw_wr_data;

      if (wr_enable) enable_q <= sw_wr_data[IRQ_W-1:0];

      pending_q <= pend_next;
    end
  end
endmodule

// File: rtl/irq_redirect_out.sv
module irq_redirect_out #(
  parameter int          DATA_W       = 32,
  parameter logic [31:0] HANDLER_ADDR = 32'h0000_0020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              save_ok,
  input  logic [DATA_W-1:0] pc,
  output logic              redirect,
  output logic [DATA_W-1:0] redirect_pc,
  output logic              ea_wr_en,
  output logic [DATA_W-1:0] ea_wr_data
);
  localparam logic [DATA_W-1:0] TARGET = DATA_W'(HANDLER_ADDR);
  localparam logic [DATA_W-1:0] STEP   = DATA_W'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect    <= 1'b0;
      redirect_pc <= '0;
      ea_wr_en    <= 1'b0;
      ea_wr_data  <= '0;
    end else begin
      redirect    <= take;
      redirect_pc <= take ? TARGET : '0;
      ea_wr_en    <= take && save_ok;
      ea_wr_data  <= (take && save_ok) ? (pc + STEP) : '0;
    end
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter int          DATA_W       = 32,
  parameter int          IRQ_W        = 32,
  parameter int          EH_BIT       = 22,
  parameter logic [31:0] STATUS_RST   = 32'h0080_0000,
  parameter logic [31:0] HANDLER_ADDR = 32'h0000_0020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IRQ_W-1:0]  irq_req,
  input  logic [DATA_W-1:0] pc,
  input  logic              sw_wr_en,
  input  logic [1:0]        sw_wr_sel,
  input  logic [DATA_W-1:0] sw_wr_data,
  input  logic              sw_clr_en,
  input  logic [IRQ_W-1:0]  sw_clr_mask,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] saved_status_q,
  output logic [IRQ_W-1:0]  enable_q,
  output logic [IRQ_W-1:0]  pending_q,
  output logic              redirect,
  output logic [DATA_W-1:0] redirect_pc,
  output logic              ea_wr_en,
  output logic [DATA_W-1:0] ea_wr_data
);
  logic [IRQ_W-1:0] en_set;
  logic             take;
  logic             save_ok;

  irq_take_decide #(.IRQ_W(IRQ_W)) u_decide (
    .gie       (status_q[0]),
    .enable_q  (enable_q),
    .irq_req   (irq_req),
    .pending_q (pending_q),
    .en_set    (en_set),
    .take      (take)
  );

  irq_ctrl_regs #(
    .DATA_W(DATA_W), .IRQ_W(IRQ_W), .EH_BIT(EH_BIT), .STATUS_RST(STATUS_RST)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .en_set      (en_set),
    .sw_wr_en    (sw_wr_en),
    .sw_wr_sel   (sw_wr_sel),
    .sw_wr_data  (sw_wr_data),
    .sw_clr_en   (sw_clr_en),
    .sw_clr_mask (sw_clr_mask),
    .status_q    (status_q),
    .saved_q     (saved_status_q),
    .enable_q    (enable_q),
    .pending_q   (pending_q),
    .save_ok     (save_ok)
  );

  irq_redirect_out #(.DATA_W(DATA_W), .HANDLER_ADDR(HANDLER_ADDR)) u_out (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .save_ok     (save_ok),
    .pc          (pc),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .ea_wr_en    (ea_wr_en),
    .ea_wr_data  (ea_wr_data)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int          DATA_W       = 32,
  parameter int          IRQ_W        = 32,
  parameter int          EH_BIT       = 22,
  parameter logic [31:0] HANDLER_ADDR = 32'h0000_0020
) (
  input logic              clk,
  input logic              rst,
  input logic [IRQ_W-1:0]  irq_req,
  input logic [DATA_W-1:0] pc,
  input logic              sw_wr_en,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] saved_status_q,
  input logic [IRQ_W-1:0]  enable_q,
  input logic [IRQ_W-1:0]  pending_q,
  input logic              redirect,
  input logic [DATA_W-1:0] redirect_pc,
  input logic              ea_wr_en,
  input logic [DATA_W-1:0] ea_wr_data
);
  p_gie_r2: assert property (@(posedge clk) disable iff (rst)
    !status_q[0] |=> !redirect);

  p_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    redirect |-> ($past(enable_q & irq_req) != '0));

  p_differs_r4: assert property (@(posedge clk) disable iff (rst)
    redirect |-> ($past(enable_q & irq_req) != $past(pending_q)));

  p_merge_r5: assert property (@(posedge clk) disable iff (rst)
    redirect |-> ((pending_q & $past(enable_q & irq_req)) == $past(enable_q & irq_req)));

  p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !redirect);

  p_target_r6: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (redirect_pc == DATA_W'(HANDLER_ADDR) && !status_q[0]));

  p_retaddr_r7: assert property (@(posedge clk) disable iff (rst)
    ea_wr_en |-> (redirect && ea_wr_data == $past(pc) + DATA_W'(4)
                  && saved_status_q == $past(status_q)));

  p_nested_r8: assert property (@(posedge clk) disable iff (rst)
    (redirect && $past(status_q[EH_BIT]) && !$past(sw_wr_en))
      |-> (!ea_wr_en && saved_status_q == $past(saved_status_q)));
endmodule

bind irq_entry_ctrl irq_entry_chk #(
  .DATA_W(DATA_W), .IRQ_W(IRQ_W), .EH_BIT(EH_BIT), .HANDLER_ADDR(HANDLER_ADDR)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .irq_req        (irq_req),
  .pc             (pc),
  .sw_wr_en       (sw_wr_en),
  .status_q       (status_q),
  .saved_status_q (saved_status_q),
  .enable_q       (enable_q),
  .pending_q      (pending_q),
  .redirect       (redirect),
  .redirect_pc    (redirect_pc),
  .ea_wr_en       (ea_wr_en),
  .ea_wr_data     (ea_wr_data)
);

// File: tb/tb_irq_entry_ctrl.sv
`timescale 1ns/1ps
module tb_irq_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_req = '0, pc = '0, sw_wr_data = '0, sw_clr_mask = '0;
  logic        sw_wr_en = 1'b0, sw_clr_en = 1'b0;
  logic [1:0]  sw_wr_sel = '0;
  logic [31:0] status_q, saved_status_q, enable_q, pending_q, redirect_pc, ea_wr_data;
  logic        redirect, ea_wr_en;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  logic [31:0] m_status, m_saved, m_enable, m_pending;

  always #4 clk = ~clk;

  irq_entry_ctrl dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .pc(pc),
    .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel), .sw_wr_data(sw_wr_data),
    .sw_clr_en(sw_clr_en), .sw_clr_mask(sw_clr_mask),
    .status_q(status_q), .saved_status_q(saved_status_q),
    .enable_q(enable_q), .pending_q(pending_q),
    .redirect(redirect), .redirect_pc(redirect_pc),
    .ea_wr_en(ea_wr_en), .ea_wr_data(ea_wr_data)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  function automatic logic is_take(input logic [31:0] req);
    logic [31:0] es;
    es = m_enable & req;
    return m_status[0] && (es != 0) && (es != m_pending);
  endfunction

  // One cycle: drive at negedge, model, sample 2 ns after the edge.
  task automatic step(input string tag, input logic [31:0] req, input logic [31:0] cur_pc,
                      input logic we, input logic [1:0] sel, input logic [31:0] d,
                      input logic ce, input logic [31:0] m);
    logic [31:0] es, n_st, n_sv, n_en, n_pd, e_rpc, e_ea;
    logic t, sv;
    irq_req = req; pc = cur_pc; sw_wr_en = we; sw_wr_sel = sel;
    sw_wr_data = d; sw_clr_en = ce; sw_clr_mask = m;
    es = m_enable & req;
    t  = is_take(req);
    sv = t && !m_status[22];
    n_st = t ? (m_status & ~32'd1) : ((we && sel == 2'd0) ? d : m_status);
    n_sv = sv ? m_status : ((we && sel == 2'd1) ? d : m_saved);
    n_en = (we && sel == 2'd2) ? d : m_enable;
    n_pd = t ? (m_pending | es)
             : (((we && sel == 2'd3) ? d : m_pending) & ~(ce ? m : 32'd0));
    e_rpc = t ? 32'h20 : 32'h0;
    e_ea  = sv ? cur_pc + 32'd4 : 32'h0;
    @(posedge clk); #2;
    chk(tag, "redirect R3/R6", {31'd0, redirect}, {31'd0, t});
    chk(tag, "redirect_pc R6", redirect_pc, e_rpc);
    chk(tag, "status R6/R10", status_q, n_st);
    chk(tag, "saved R7/R8", saved_status_q, n_sv);
    chk(tag, "enable R11", enable_q, n_en);
    chk(tag, "pending R5/R9", pending_q, n_pd);
    chk(tag, "ea_wr_en R7/R8", {31'd0, ea_wr_en}, {31'd0, sv});
    chk(tag, "ea_wr_data R7", ea_wr_data, e_ea);
    m_status = n_st; m_saved = n_sv; m_enable = n_en; m_pending = n_pd;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;
    // R1: reset values
    chk("R1", "status", status_q, 32'h0080_0000);
    chk("R1", "saved", saved_status_q, 32'h0);
    chk("R1", "enable", enable_q, 32'h0);
    chk("R1", "pending", pending_q, 32'h0);
    chk("R1", "redirect", {31'd0, redirect}, 32'h0);
    chk("R1", "ea_wr_en", {31'd0, ea_wr_en}, 32'h0);
    m_status = 32'h0080_0000; m_saved = 0; m_enable = 0; m_pending = 0;
    @(negedge clk);

    // R11: write enable, R2: global enable clear blocks entry
    step("R11", 32'h0, 32'h100, 1, 2'd2, 32'h0000_0005, 0, 0);
    step("R2", 32'h5, 32'h104, 0, 0, 0, 0, 0);
    // R3: requests with enable clear do nothing
    step("R11", 32'h0, 32'h108, 1, 2'd0, 32'h0000_0001, 0, 0);
    step("R3", 32'h0000_00A0, 32'h10C, 0, 0, 0, 0, 0);
    // R7: first entry with flag clear
    step("R7", 32'h1, 32'h200, 0, 0, 0, 0, 0);
    step("R6", 32'h1, 32'h204, 0, 0, 0, 0, 0);
    // R4: enabled set equals pending -> no entry
    step("R11", 32'h1, 32'h208, 1, 2'd0, 32'h0000_0001, 0, 0);
    step("R4", 32'h1, 32'h20C, 0, 0, 0, 0, 0);
    // subset of pending still differs -> entry, pending stays
    step("R11", 32'h0, 32'h210, 1, 2'd3, 32'h0000_0005, 0, 0);
    step("R5", 32'h1, 32'h214, 0, 0, 0, 0, 0);
    // R9: clear by mask
    step("R9", 32'h0, 32'h218, 0, 0, 0, 1, 32'h0000_0004);
    step("R9", 32'h0, 32'h21C, 0, 0, 0, 1, 32'hFFFF_FFFF);
    // R8: nested entry with flag set
    step("R11", 32'h0, 32'h220, 1, 2'd1, 32'hCAFE_0000, 0, 0);
    step("R11", 32'h0, 32'h224, 1, 2'd0, 32'h0040_0001, 0, 0);
    step("R8", 32'h4, 32'h228, 0, 0, 0, 0, 0);
    // R10: status write collides with entry; saved write collides with save
    step("R11", 32'h0, 32'h230, 1, 2'd0, 32'h0000_0001, 1, 32'hFFFF_FFFF);
    step("R10", 32'h1, 32'h234, 1, 2'd0, 32'h0000_0003, 0, 0);
    step("R11", 32'h0, 32'h238, 1, 2'd0, 32'h0000_0001, 1, 32'hFFFF_FFFF);
    step("R10", 32'h4, 32'h23C, 1, 2'd1, 32'h1234_5678, 0, 0);
    // R7: return address wraps
    step("R11", 32'h0, 32'h0, 1, 2'd0, 32'h0000_0001, 1, 32'hFFFF_FFFF);
    step("R7", 32'h1, 32'hFFFF_FFFC, 0, 0, 0, 0, 0);
    // R11: simultaneous pending write and clear
    step("R11", 32'h0, 32'h300, 1, 2'd3, 32'h0000_00FF, 1, 32'h0000_000F);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] req, d, m;
      logic we, ce;
      logic [1:0] sel;
      req = $urandom() & $urandom() & $urandom();
      we  = ($urandom_range(0, 3) == 0);
      sel = 2'($urandom_range(0, 3));
      d   = $urandom();
      if (sel == 2'd0) d = {9'd0, d[22], 21'd0, ($urandom_range(0, 3) != 0)};
      ce  = ($urandom_range(0, 4) == 0);
      m   = $urandom();
      step("R5", req, $urandom(), we, sel, d, ce, m);
    end
    finish_run();
  end
endmodule